// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block takes a master clock and produces a system clock enable at half its rate. A master clock of up to 120 MHz therefore gives a system rate of up to 60 MHz. From that enable it derives separate enables for the core, for memory and for each peripheral. A three-state power-mode machine (Run, Wait, Stop) and a peripheral enable register decide which enables pulse. The outputs are synchronous clock enables, not real clock gates: each one is high for one master cycle at the system rate. Downstream logic qualifies its flops with them.

The core signals Wait and Stop through one-cycle strobes. An unmasked interrupt brings the block back from Wait. Stop ends only in one of two ways: on a bus-traffic wake or a non-clocked interrupt wake, or on a reset. The reset input covers power-on, external and watchdog resets. When bus traffic ends Stop, a flag marks the first message as lost. The watchdog enable is never gated, so a watchdog reset can always end Stop.

Software writes the peripheral enable register through a plain write strobe and data bus. All mode changes and register updates wait for a system-clock boundary, so no gated enable is ever cut short.

Top module: `pwr_clk_gate_ctrl`

## Requirements
- R1: `sys_ce` is high on every second master cycle and low on the others, giving half the master rate.
- R2: After reset, `mode` is Run (2'b00), every peripheral enable bit is 1 and `msg_lost` is 0.
- R3: In Run, `core_ce` and `mem_ce` pulse with `sys_ce`, and `periph_ce[i]` pulses with `sys_ce` only while enable bit i is 1.
- R4: A `wait_req` strobe in Run moves `mode` to Wait (2'b01). In Wait, `core_ce` and `mem_ce` stay low while `periph_ce` keeps following the enable bits.
- R5: An `irq_unmasked` pulse in Wait returns `mode` to Run. In Run or Stop it has no effect.
- R6: A `stop_req` strobe in Run moves `mode` to Stop (2'b10) and wins over a `wait_req` given in the same window. In Stop, `core_ce`, `mem_ce` and all `periph_ce` stay low while `sys_ce` keeps running. A `stop_req` given in Wait is ignored.
- R7: Stop is left only through `wake_bus`, `wake_nclk` or reset.
- R8: When `wake_bus` ends Stop, `msg_lost` is high for exactly two master cycles after the change to Run. A wake through `wake_nclk`, or a `wake_bus` pulse outside Stop, leaves `msg_lost` low.
- R9: A write (`pce_wr`, `pce_wdata`) replaces the enable register in any mode. Bit i gates peripheral i, and bit 0 is the second CAN controller.
- R10: `wdog_ce` pulses with `sys_ce` in every mode, whatever the enable bits hold.
- R11: `mode` changes only on master edges at which `sys_ce` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset (power-on, external or watchdog) |
| wait_req | input | 1 | Wait request strobe from the core |
| stop_req | input | 1 | Stop request strobe from the core |
| irq_unmasked | input | 1 | Some unmasked interrupt is pending |
| wake_bus | input | 1 | Bus-traffic wake indication |
| wake_nclk | input | 1 | Non-clocked interrupt wake indication |
| pce_wr | input | 1 | Peripheral enable register write strobe |
| pce_wdata | input | NUM_PERIPH | Peripheral enable write data |
| sys_ce | output | 1 | Half-rate system clock enable |
| core_ce | output | 1 | Core clock enable |
| mem_ce | output | 1 | Memory clock enable |
| periph_ce | output | NUM_PERIPH | Per-peripheral clock enables |
| wdog_ce | output | 1 | Watchdog clock enable, never gated |
| mode | output | 2 | Current power mode |
| msg_lost | output | 1 | First message after a bus wake was lost |

## Verification
A wrong internal mode shows at the ports within one system period, at most two master cycles. It appears as `core_ce`, `mem_ce` or `periph_ce` pulsing when they should be quiet, or staying quiet when they should pulse, and as a wrong `mode` value. A corrupted enable register shows as a wrong `periph_ce` pattern at the next system tick. A divider that loses phase shows at once as two adjacent `sys_ce` cycles with the same value. A wake that takes the wrong path shows in the two-cycle `msg_lost` window right after Stop ends.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/pgc_divider.sv
module pgc_divider (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign tick = phase_q;
endmodule

// File: rtl/pgc_mode_fsm.sv
module pgc_mode_fsm
  import pgc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     wait_req,
  input  logic     stop_req,
  input  logic     irq_unmasked,
  input  logic     wake_bus,
  input  logic     wake_nclk,
  output pm_mode_e mode,
  output logic     msg_lost
);
  logic wait_p, stop_p, irq_p, bus_p, nclk_p;
  logic wait_any, stop_any, irq_any, bus_any, nclk_any;

  // Strobes seen between boundaries are held until the next tick.
  assign wait_any = wait_p | wait_req;
  assign stop_any = stop_p | stop_req;
  assign irq_any  = irq_p  | irq_unmasked;
  assign bus_any  = bus_p  | wake_bus;
  assign nclk_any = nclk_p | wake_nclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= PM_RUN;
      msg_lost <= 1'b0;
      wait_p   <= 1'b0;
      stop_p   <= 1'b0;
      irq_p    <= 1'b0;
      bus_p    <= 1'b0;
      nclk_p   <= 1'b0;
    end else if (tick) begin
      wait_p   <= 1'b0;
      stop_p   <= 1'b0;
      irq_p    <= 1'b0;
      bus_p    <= 1'b0;
      nclk_p   <= 1'b0;
      msg_lost <= 1'b0;
      unique case (mode)
        PM_RUN: begin
          if (stop_any)      mode <= PM_STOP;
          else if (wait_any) mode <= PM_WAIT;
        end
        PM_WAIT: begin
          if (irq_any) mode <= PM_RUN;
        end
        PM_STOP: begin
          if (bus_any) begin
            mode     <= PM_RUN;
            msg_lost <= 1'b1;
          end else if (nclk_any) begin
            mode <= PM_RUN;
          end
        end
        default: mode <= PM_RUN;
      endcase
    end else begin
      wait_p <= wait_any;
      stop_p <= stop_any;
      irq_p  <= irq_any;
      bus_p  <= bus_any;
      nclk_p <= nclk_any;
    end
  end
endmodule

// File: rtl/pgc_enable_reg.sv
module pgc_enable_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] en
);
  logic             pend_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_now;

  assign data_now = wr ? wdata : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '1;
      pend_q <= 1'b0;
      data_q <= '1;
    end else begin
      if (wr) data_q <= wdata;
      if (tick) begin
        if (pend_q || wr) en <= data_now;
        pend_q <= 1'b0;
      end else if (wr) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_clk_gate_ctrl.sv
module pwr_clk_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8
) (
  input  logic                  clk_mst,
  input  logic                  rst_n,
  input  logic                  wait_req,
  input  logic                  stop_req,
  input  logic                  irq_unmasked,
  input  logic                  wake_bus,
  input  logic                  wake_nclk,
  input  logic                  pce_wr,
  input  logic [NUM_PERIPH-1:0] pce_wdata,
  output logic                  sys_ce,
  output logic                  core_ce,
  output logic                  mem_ce,
  output logic [NUM_PERIPH-1:0] periph_ce,
  output logic                  wdog_ce,
  output logic [1:0]            mode,
  output logic                  msg_lost
);
  logic                  tick;
  pm_mode_e              mode_q;
  logic [NUM_PERIPH-1:0] en_bits;
  logic                  sys_on, per_on;

  pgc_divider u_div (
    .clk   (clk_mst),
    .rst_n (rst_n),
    .tick  (tick)
  );

  pgc_mode_fsm u_fsm (
    .clk          (clk_mst),
    .rst_n        (rst_n),
    .tick         (tick),
    .wait_req     (wait_req),
    .stop_req     (stop_req),
    .irq_unmasked (irq_unmasked),
    .wake_bus     (wake_bus),
    .wake_nclk    (wake_nclk),
    .mode         (mode_q),
    .msg_lost     (msg_lost)
  );

  pgc_enable_reg #(.WIDTH(NUM_PERIPH)) u_pce (
    .clk   (clk_mst),
    .rst_n (rst_n),
    .tick  (tick),
    .wr    (pce_wr),
    .wdata (pce_wdata),
    .en    (en_bits)
  );

  assign sys_on  = (mode_q == PM_RUN);
  assign per_on  = (mode_q != PM_STOP);

  assign sys_ce  = tick;
  assign wdog_ce = tick;
  assign core_ce = tick & sys_on;
  assign mem_ce  = tick & sys_on;
  assign mode    = mode_q;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_gate
    assign periph_ce[i] = tick & per_on & en_bits[i];
  end
endmodule

// File: rtl/pwr_clk_gate_ctrl_chk.sv
module pwr_clk_gate_ctrl_chk #(
  parameter int unsigned NUM_PERIPH = 8
) (
  input logic                  clk_mst,
  input logic                  rst_n,
  input logic                  sys_ce,
  input logic                  core_ce,
  input logic                  mem_ce,
  input logic [NUM_PERIPH-1:0] periph_ce,
  input logic                  wdog_ce,
  input logic [1:0]            mode,
  input logic                  msg_lost
);
  assert_tick_falls_R1: assert property (@(posedge clk_mst) disable iff (!rst_n)
    sys_ce |=> !sys_ce);
  assert_tick_rises_R1: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !sys_ce |=> sys_ce);
  assert_core_run_only_R3: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (core_ce || mem_ce) |-> (mode == 2'b00 && sys_ce));
  assert_wait_gates_core_R4: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (mode == 2'b01) |-> (!core_ce && !mem_ce));
  assert_stop_gates_all_R6: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (mode == 2'b10) |-> (periph_ce == '0 && !core_ce));
  assert_wdog_in_stop_R10: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (mode == 2'b10 && sys_ce) |-> wdog_ce);
  assert_mode_on_boundary_R11: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !$stable(mode) |-> $past(sys_ce));
  assert_lost_after_stop_R8: assert property (@(posedge clk_mst) disable iff (!rst_n)
    $rose(msg_lost) |-> (mode == 2'b00 && $past(mode) == 2'b10));
  assert_mode_legal_R2: assert property (@(posedge clk_mst) disable iff (!rst_n)
    mode != 2'b11);
endmodule

bind pwr_clk_gate_ctrl pwr_clk_gate_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk_mst   (clk_mst),
  .rst_n     (rst_n),
  .sys_ce    (sys_ce),
  .core_ce   (core_ce),
  .mem_ce    (mem_ce),
  .periph_ce (periph_ce),
  .wdog_ce   (wdog_ce),
  .mode      (mode),
  .msg_lost  (msg_lost)
);

// File: tb/pwr_clk_gate_ctrl_tb.sv
module pwr_clk_gate_ctrl_tb;
  localparam int NP = 4;
  localparam logic [1:0] RUN = 2'b00, WT = 2'b01, STP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, irq_unmasked = 0, wake_bus = 0, wake_nclk = 0;
  logic pce_wr = 0;
  logic [NP-1:0] pce_wdata = '0;
  logic sys_ce, core_ce, mem_ce, wdog_ce, msg_lost;
  logic [NP-1:0] periph_ce;
  logic [1:0] mode;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_clk_gate_ctrl #(.NUM_PERIPH(NP)) u_dut (
    .clk_mst(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .irq_unmasked(irq_unmasked), .wake_bus(wake_bus), .wake_nclk(wake_nclk),
    .pce_wr(pce_wr), .pce_wdata(pce_wdata), .sys_ce(sys_ce), .core_ce(core_ce),
    .mem_ce(mem_ce), .periph_ce(periph_ce), .wdog_ce(wdog_ce), .mode(mode),
    .msg_lost(msg_lost));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // which: 0 wait, 1 stop, 2 irq, 3 bus, 4 nclk, 5 wait+stop
  task automatic strobe(input int which);
    case (which)
      0: wait_req = 1;
      1: stop_req = 1;
      2: irq_unmasked = 1;
      3: wake_bus = 1;
      4: wake_nclk = 1;
      default: begin wait_req = 1; stop_req = 1; end
    endcase
    cyc(1);
    {wait_req, stop_req, irq_unmasked, wake_bus, wake_nclk} = '0;
    cyc(3);
  endtask

  task automatic write_pce(input logic [NP-1:0] v);
    pce_wr = 1; pce_wdata = v;
    cyc(1);
    pce_wr = 0;
    cyc(3);
  endtask

  // Two adjacent master cycles hold exactly one system tick.
  task automatic window(output logic c, output logic m, output logic [NP-1:0] p,
                        output logic s, output logic w, output logic l);
    c = 0; m = 0; p = '0; s = 0; w = 0; l = 0;
    repeat (2) begin
      @(negedge clk);
      c |= core_ce; m |= mem_ce; p |= periph_ce; s |= sys_ce; w |= wdog_ce; l |= msg_lost;
    end
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic c, m, s, w, l;
    logic [NP-1:0] p;
    int hi, adj;
    logic prev;

    do_reset();
    // R2 reset state
    chk("R2 mode", mode, RUN);
    chk("R2 msg_lost", msg_lost, 0);
    window(c, m, p, s, w, l);
    chk("R2 enables all ones", p, {NP{1'b1}});
    chk("R3 core/mem in run", {c, m}, 2'b11);

    // R1 half-rate divider
    hi = 0; adj = 0;
    @(negedge clk); prev = sys_ce;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hi += sys_ce;
      if (sys_ce == prev) adj++;
      prev = sys_ce;
    end
    #1;
    chk("R1 ticks in 20", hi, 10);
    chk("R1 no equal neighbours", adj, 0);

    // R3/R9/R4/R5/R10 sweep of every enable value in Run and Wait
    for (int v = 0; v < (1 << NP); v++) begin
      write_pce(NP'(v));
      window(c, m, p, s, w, l);
      chk("R9 run periph", p, v);
      chk("R3 run core", {c, m}, 2'b11);
      chk("R10 wdog run", w, 1);
      strobe(0);
      chk("R4 mode wait", mode, WT);
      window(c, m, p, s, w, l);
      chk("R4 wait periph", p, v);
      chk("R4 wait core off", {c, m}, 2'b00);
      strobe(1);
      chk("R6 stop ignored in wait", mode, WT);
      strobe(2);
      chk("R5 irq wakes wait", mode, RUN);
    end

    // R5 irq in run has no effect
    strobe(2);
    chk("R5 irq in run", mode, RUN);

    // R9 write during Wait lands and shows
    strobe(0);
    write_pce(4'b1010);
    window(c, m, p, s, w, l);
    chk("R9 write in wait", p, 4'b1010);
    strobe(2);

    // R6 stop gating, priority over wait
    write_pce(4'b1111);
    strobe(5);
    chk("R6 stop wins", mode, STP);
    window(c, m, p, s, w, l);
    chk("R6 stop periph off", p, 0);
    chk("R6 stop core off", {c, m}, 2'b00);
    chk("R6 sys runs", s, 1);
    chk("R10 wdog in stop", w, 1);

    // R7 irq and wait do not leave stop
    strobe(2);
    chk("R7 irq ignored in stop", mode, STP);
    strobe(0);
    chk("R7 wait ignored in stop", mode, STP);

    // R8 bus wake sets msg_lost for two cycles
    wake_bus = 1;
    cyc(1);
    wake_bus = 0;
    hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); hi += msg_lost; end
    #1;
    chk("R7 bus wake to run", mode, RUN);
    chk("R8 msg_lost width", hi, 2);

    // R8 nclk wake: no flag
    strobe(1);
    chk("R6 stop again", mode, STP);
    wake_nclk = 1;
    cyc(1);
    wake_nclk = 0;
    hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); hi += msg_lost; end
    #1;
    chk("R7 nclk wake to run", mode, RUN);
    chk("R8 nclk no flag", hi, 0);

    // R8 bus pulse in run: no flag
    wake_bus = 1;
    cyc(1);
    wake_bus = 0;
    hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); hi += msg_lost; end
    #1;
    chk("R8 bus in run no flag", hi, 0);
    chk("R8 bus in run mode", mode, RUN);

    // R2 reset ends stop and restores enables
    write_pce(4'b0001);
    strobe(1);
    chk("R6 stop before reset", mode, STP);
    do_reset();
    chk("R2 reset leaves stop", mode, RUN);
    window(c, m, p, s, w, l);
    chk("R2 enables after reset", p, {NP{1'b1}});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule